// File: doc/BRIEF.md
# Multi-Table Banked Memory Mapper

This block sits between a CPU with a 16-bit address bus and a wider physical system bus. The top three CPU address bits pick one of eight 8 kB windows. Each window is translated through a bank entry to a 10-bit physical bank number, and the bank number is joined to the 13-bit offset inside the window. Four complete mapping tables are held. One of them, the active table, translates the addresses. A second selector names the table that software edits, so a table can be prepared while a different table stays in use.

Two control bytes are always present at CPU addresses 0 and 1. The edit registers ($0002–$0003 for the upper bank bits and $0008–$000F for the lower eight bits) appear only while editing is enabled. At all other times those addresses fall through to ordinary memory. Unless it is switched off, an I/O page overlays window 6 ($C000–$DFFF). Each translated bank is decoded into a single region select: SRAM, flash, cartridge, I/O, or a reserved flag.

Top module: `bank_mapper`

## Requirements
- R1: After synchronous reset, both table selectors are 0, editing is off, extended SRAM is off, the I/O overlay is on with page 0, and every table holds the identity map, so window n translates to bank n.
- R2: Outside the I/O overlay, phys_addr equals the active table's bank entry for window cpu_addr[15:13], concatenated with cpu_addr[12:0].
- R3: Address $0000 holds the mode byte. Its bits 1:0 are the active table, bit 3 is extended SRAM enable, bits 5:4 are the edit table, and bit 7 is edit enable. Bits 2 and 6 read as 0. Address $0001 holds the I/O byte. Its bits 1:0 are the page, bit 2 disables the overlay, bit 3 is the page extension (page bit 2), and bits 6:4 are stored and read back without effect. Bit 7 reads as 0. Both bytes are always claimed (reg_hit=1) and read back.
- R4: While edit enable is 1, a write to $0008+w (w = 0..7) sets bits 7:0 of window w's entry in the edit table. A read of that address returns those bits.
- R5: While edit enable is 1, $0002 carries bank bits 9:8 for windows 0–3 and $0003 carries them for windows 4–7. Window 4k+j uses data bits 2j+1:2j. These addresses can be written and read back.
- R6: Edits change only the edit-selected table. Translation through a different active table does not change.
- R7: While edit enable is 0, $0002–$000F are not claimed (reg_hit=0, cpu_rdata=0). Writes to them leave every table unchanged, and the access is translated like any other window-0 address.
- R8: When the overlay is on and cpu_addr[15:13]=6, io_sel=1 for page {ext,page} values 0–5. phys_addr is then page·8 kB + offset, and io_page gives the page number. Pages 6 and 7 raise rsvd_flag instead of io_sel.
- R9: When the overlay disable bit is 1, window 6 is translated through the active table like any other window.
- R10: A bank with bits 9:8 = 0 decodes by its low byte: $00–$3F SRAM, $40–$7F flash, $80–$9F cartridge, $A0–$FF reserved. Banks $100–$13F, $200–$23F and $300–$33F are SRAM only when extended SRAM is enabled. Every other bank of $100 or above is reserved.
- R11: At most one of sram_sel, flash_sel, cart_sel, io_sel and rsvd_flag is 1. A reserved bank drives no select. All five are 0 while reg_hit=1.
- R12: A register write changes state at the clock edge. Translation and read data are combinational, so the new value is seen from the next cycle on, and not in the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, sampled at the clock edge |
| cpu_rdata | output | 8 | Register read data, 0 when not claimed |
| reg_hit | output | 1 | The access targets a mapper register |
| phys_addr | output | 23 | Physical address: bank (10) joined to offset (13) |
| sram_sel | output | 1 | Access targets SRAM |
| flash_sel | output | 1 | Access targets flash |
| cart_sel | output | 1 | Access targets cartridge |
| io_sel | output | 1 | Access targets the overlaid I/O page |
| io_page | output | 3 | Selected I/O page number |
| rsvd_flag | output | 1 | Access falls in a reserved range |

## Verification
On every cycle the assertions check these invariants: the offset passes through unchanged, the select outputs are mutually exclusive and quiet on register hits, the two control bytes are always claimed, the edit addresses are not claimed while editing is off, I/O selection occurs only in window 6, SRAM decode stays below bank $40 in the base page, and a mode write lands on the next edge. Only the bench scenarios can show the things that need stored history. These are the identity contents after reset, the packing of the upper bank bits, the separation of the edit table from the active table, writes that are ignored while editing is off, and the full region decode of programmed entries. A reference model in the bench tracks those tables and is compared with every output on every cycle.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
    localparam int CPU_AW   = 16;
    localparam int DW       = 8;
    localparam int OFF_W    = 13;
    localparam int WIN_W    = CPU_AW - OFF_W;
    localparam int NUM_WIN  = 1 << WIN_W;
    localparam int TBL_W    = 2;
    localparam int NUM_TBL  = 1 << TBL_W;
    localparam int BANK_W   = 10;
    localparam int HI_W     = BANK_W - DW;
    localparam int HI_PER   = DW / HI_W;
    localparam int PHYS_AW  = BANK_W + OFF_W;
    localparam int IO_PG_W  = 3;
    localparam int IO_WIN   = 6;
    localparam int IO_PAGES = 6;

    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        logic             edit_en;
        logic [TBL_W-1:0] edit_tbl;
        logic             ext_sram;
        logic [TBL_W-1:0] act_tbl;
    } mode_t;

    typedef struct packed {
        logic       spr;
        logic       mv_flash;
        logic       mv_io;
        logic       pg_ext;
        logic       io_off;
        logic [1:0] pg;
    } ioctl_t;

    typedef enum logic [2:0] {
        RGN_NONE, RGN_SRAM, RGN_FLASH, RGN_CART, RGN_IO, RGN_RSVD
    } region_e;

    function automatic region_e decode_bank(bank_t b, logic ext);
        region_e r;
        if (b[BANK_W-1:DW] == '0) begin
            case (b[7:6])
                2'd0:    r = RGN_SRAM;
                2'd1:    r = RGN_FLASH;
                2'd2:    r = b[5] ? RGN_RSVD : RGN_CART;
                default: r = RGN_RSVD;
            endcase
        end else begin
            r = (ext && b[7:6] == 2'd0) ? RGN_SRAM : RGN_RSVD;
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] mode_byte(mode_t m);
        return {m.edit_en, 1'b0, m.edit_tbl, m.ext_sram, 1'b0, m.act_tbl};
    endfunction

    function automatic logic [DW-1:0] ioctl_byte(ioctl_t c);
        return {1'b0, c};
    endfunction
endpackage

// File: rtl/bmap_ctrl.sv
module bmap_ctrl
    import bmap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_we,
    input  logic          io_we,
    input  logic [DW-1:0] wdata,
    output mode_t         mode,
    output ioctl_t        ioc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            ioc  <= '0;
        end else begin
            if (mode_we) begin
                mode.edit_en  <= wdata[7];
                mode.edit_tbl <= wdata[5:4];
                mode.ext_sram <= wdata[3];
                mode.act_tbl  <= wdata[1:0];
            end
            if (io_we)
                ioc <= ioctl_t'(wdata[6:0]);
        end
    end
endmodule

// File: rtl/bmap_tables.sv
module bmap_tables
    import bmap_pkg::*;
#(
    parameter int N_TBL = NUM_TBL,
    parameter int N_WIN = NUM_WIN,
    parameter int BW    = BANK_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(N_TBL)-1:0]    act_tbl,
    input  logic [$clog2(N_TBL)-1:0]    edit_tbl,
    input  logic                        lo_we,
    input  logic                        hi_we,
    input  logic [$clog2(N_WIN)-1:0]    lo_win,
    input  logic                        hi_grp,
    input  logic [DW-1:0]               wdata,
    output logic [N_WIN-1:0][BW-1:0]    act_banks,
    output logic [N_WIN-1:0][BW-1:0]    edit_banks
);
    localparam int HW  = BW - DW;
    localparam int PER = DW / HW;

    logic [N_TBL-1:0][N_WIN-1:0][BW-1:0] mem;

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        for (genvar w = 0; w < N_WIN; w++) begin : g_win
            localparam int GRP = w / PER;
            localparam int SUB = w % PER;
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[t][w] <= BW'(w);
                end else if (edit_tbl == t) begin
                    if (lo_we && lo_win == w)
                        mem[t][w][DW-1:0] <= wdata;
                    if (hi_we && int'(hi_grp) == GRP)
                        mem[t][w][BW-1:DW] <= wdata[SUB*HW +: HW];
                end
            end
        end
    end

    assign act_banks  = mem[act_tbl];
    assign edit_banks = mem[edit_tbl];
endmodule

// File: rtl/bmap_xlate.sv
module bmap_xlate
    import bmap_pkg::*;
(
    input  logic [CPU_AW-1:0]              cpu_addr,
    input  logic [NUM_WIN-1:0][BANK_W-1:0] act_banks,
    input  mode_t                          mode,
    input  ioctl_t                         ioc,
    input  logic                           claimed,
    output logic [PHYS_AW-1:0]             phys_addr,
    output region_e                        region
);
    logic [WIN_W-1:0]   win;
    logic [OFF_W-1:0]   off;
    logic [IO_PG_W-1:0] pg;
    bank_t              bank;
    region_e            raw;

    assign win = cpu_addr[CPU_AW-1:OFF_W];
    assign off = cpu_addr[OFF_W-1:0];
    assign pg  = {ioc.pg_ext, ioc.pg};

    always_comb begin
        bank = act_banks[win];
        if (!ioc.io_off && win == WIN_W'(IO_WIN)) begin
            phys_addr = {{(BANK_W-IO_PG_W){1'b0}}, pg, off};
            raw       = (int'(pg) < IO_PAGES) ? RGN_IO : RGN_RSVD;
        end else begin
            phys_addr = {bank, off};
            raw       = decode_bank(bank, mode.ext_sram);
        end
        region = claimed ? RGN_NONE : raw;
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic [DW-1:0]       cpu_wdata,
    input  logic                cpu_we,
    output logic [DW-1:0]       cpu_rdata,
    output logic                reg_hit,
    output logic [PHYS_AW-1:0]  phys_addr,
    output logic                sram_sel,
    output logic                flash_sel,
    output logic                cart_sel,
    output logic                io_sel,
    output logic [IO_PG_W-1:0]  io_page,
    output logic                rsvd_flag
);
    mode_t   mode;
    ioctl_t  ioc;
    region_e region;
    logic    hit_mode, hit_io, hit_hi, hit_lo;
    logic    edit_on;
    logic [TBL_W-1:0] act_sel;
    logic [DW-1:0] hi_rd;
    logic [NUM_WIN-1:0][BANK_W-1:0] act_banks, edit_banks;

    assign edit_on  = mode.edit_en;
    assign act_sel  = mode.act_tbl;
    assign hit_mode = (cpu_addr == CPU_AW'(0));
    assign hit_io   = (cpu_addr == CPU_AW'(1));
    assign hit_hi   = edit_on && (cpu_addr[CPU_AW-1:1] == (CPU_AW-1)'(1));
    assign hit_lo   = edit_on && (cpu_addr[CPU_AW-1:WIN_W] == (CPU_AW-WIN_W)'(1));
    assign reg_hit  = hit_mode | hit_io | hit_hi | hit_lo;

    bmap_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .mode_we (cpu_we && hit_mode),
        .io_we   (cpu_we && hit_io),
        .wdata   (cpu_wdata),
        .mode    (mode),
        .ioc     (ioc)
    );

    bmap_tables u_tables (
        .clk        (clk),
        .rst        (rst),
        .act_tbl    (mode.act_tbl),
        .edit_tbl   (mode.edit_tbl),
        .lo_we      (cpu_we && hit_lo),
        .hi_we      (cpu_we && hit_hi),
        .lo_win     (cpu_addr[WIN_W-1:0]),
        .hi_grp     (cpu_addr[0]),
        .wdata      (cpu_wdata),
        .act_banks  (act_banks),
        .edit_banks (edit_banks)
    );

    bmap_xlate u_xlate (
        .cpu_addr  (cpu_addr),
        .act_banks (act_banks),
        .mode      (mode),
        .ioc       (ioc),
        .claimed   (reg_hit),
        .phys_addr (phys_addr),
        .region    (region)
    );

    always_comb begin
        for (int j = 0; j < HI_PER; j++)
            hi_rd[j*HI_W +: HI_W] = edit_banks[int'(cpu_addr[0])*HI_PER + j][BANK_W-1:DW];
    end

    always_comb begin
        if (hit_mode)    cpu_rdata = mode_byte(mode);
        else if (hit_io) cpu_rdata = ioctl_byte(ioc);
        else if (hit_hi) cpu_rdata = hi_rd;
        else if (hit_lo) cpu_rdata = edit_banks[cpu_addr[WIN_W-1:0]][DW-1:0];
        else             cpu_rdata = '0;
    end

    assign sram_sel  = (region == RGN_SRAM);
    assign flash_sel = (region == RGN_FLASH);
    assign cart_sel  = (region == RGN_CART);
    assign io_sel    = (region == RGN_IO);
    assign rsvd_flag = (region == RGN_RSVD);
    assign io_page   = {ioc.pg_ext, ioc.pg};
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
    import bmap_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [CPU_AW-1:0]  cpu_addr,
    input logic [DW-1:0]      cpu_wdata,
    input logic               cpu_we,
    input logic               reg_hit,
    input logic [PHYS_AW-1:0] phys_addr,
    input logic               sram_sel,
    input logic               flash_sel,
    input logic               cart_sel,
    input logic               io_sel,
    input logic               rsvd_flag,
    input logic               edit_on,
    input logic [TBL_W-1:0]   act_sel
);
    logic any_sel;
    assign any_sel = sram_sel | flash_sel | cart_sel | io_sel | rsvd_flag;

    assert_offset_R2: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

    assert_ctrl_claim_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[CPU_AW-1:1] == '0) |-> reg_hit);

    assert_noedit_R7: assert property (@(posedge clk) disable iff (rst)
        (!edit_on && cpu_addr >= CPU_AW'(2) && cpu_addr <= CPU_AW'(15)) |-> !reg_hit);

    assert_io_window_R8: assert property (@(posedge clk) disable iff (rst)
        io_sel |-> (cpu_addr[CPU_AW-1:OFF_W] == WIN_W'(IO_WIN)));

    assert_sram_base_R10: assert property (@(posedge clk) disable iff (rst)
        (sram_sel && phys_addr[PHYS_AW-1:PHYS_AW-HI_W] == '0)
            |-> (phys_addr[PHYS_AW-HI_W-1:PHYS_AW-HI_W-2] == 2'b00));

    assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sram_sel, flash_sel, cart_sel, io_sel, rsvd_flag}));

    assert_claim_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        reg_hit |-> !any_sel);

    assert_mode_write_R12: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == '0) |=>
            (edit_on == $past(cpu_wdata[7]) && act_sel == $past(cpu_wdata[1:0])));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .reg_hit   (reg_hit),
    .phys_addr (phys_addr),
    .sram_sel  (sram_sel),
    .flash_sel (flash_sel),
    .cart_sel  (cart_sel),
    .io_sel    (io_sel),
    .rsvd_flag (rsvd_flag),
    .edit_on   (edit_on),
    .act_sel   (act_sel)
);

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
module tb_bank_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        reg_hit;
    logic [22:0] phys_addr;
    logic        sram_sel, flash_sel, cart_sel, io_sel, rsvd_flag;
    logic [2:0]  io_page;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int tbl [4][8];
    int mode_r;
    int io_r;

    always #2.5 clk = ~clk;

    bank_mapper dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .reg_hit(reg_hit),
        .phys_addr(phys_addr), .sram_sel(sram_sel), .flash_sel(flash_sel),
        .cart_sel(cart_sel), .io_sel(io_sel), .io_page(io_page),
        .rsvd_flag(rsvd_flag)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, cpu_addr, got, exp);
        end
    endtask

    // Behavioural reference of the outputs for the current inputs and state.
    task automatic model_eval(input int a, output int rd, output int hit,
                              output int phys, output int sel, output int pg);
        int ed, et, at, ext, pgl, ioff, pext, win, off, bank, hi, lo;
        ed = (mode_r >> 7) & 1; et = (mode_r >> 4) & 3; at = mode_r & 3;
        ext = (mode_r >> 3) & 1;
        pgl = io_r & 3; ioff = (io_r >> 2) & 1; pext = (io_r >> 3) & 1;
        hit = (a == 0 || a == 1 || (ed == 1 && (a == 2 || a == 3 || (a >= 8 && a <= 15)))) ? 1 : 0;
        rd = 0;
        if (a == 0) rd = mode_r & 'hBB;
        else if (a == 1) rd = io_r & 'h7F;
        else if (hit == 1 && (a == 2 || a == 3)) begin
            for (int j = 0; j < 4; j++)
                rd |= ((tbl[et][(a - 2) * 4 + j] >> 8) & 3) << (2 * j);
        end else if (hit == 1) rd = tbl[et][a - 8] & 255;
        pg = pext * 4 + pgl;
        win = a >> 13; off = a & 8191;
        if (ioff == 0 && win == 6) begin
            phys = pg * 8192 + off;
            sel = (pg < 6) ? 2 : 1;
        end else begin
            bank = tbl[at][win];
            phys = bank * 8192 + off;
            hi = bank >> 8; lo = bank & 255;
            if (hi == 0) sel = (lo < 64) ? 16 : (lo < 128) ? 8 : (lo < 160) ? 4 : 1;
            else sel = (ext == 1 && lo < 64) ? 16 : 1;
        end
        if (hit == 1) sel = 0;
    endtask

    task automatic model_write(input int a, input int wd);
        int ed, et;
        ed = (mode_r >> 7) & 1; et = (mode_r >> 4) & 3;
        if (a == 0) mode_r = wd;
        else if (a == 1) io_r = wd;
        else if (ed == 1 && (a == 2 || a == 3)) begin
            for (int j = 0; j < 4; j++)
                tbl[et][(a - 2) * 4 + j] = (tbl[et][(a - 2) * 4 + j] & 255) | (((wd >> (2 * j)) & 3) << 8);
        end else if (ed == 1 && a >= 8 && a <= 15)
            tbl[et][a - 8] = (tbl[et][a - 8] & 'h300) | wd;
    endtask

    // One bus cycle: drive at the falling edge, compare before the rising edge.
    task automatic bus(input string tag, input int a, input int wd, input bit we);
        int rd, hit, phys, sel, pg;
        cpu_addr = 16'(a); cpu_wdata = 8'(wd); cpu_we = we;
        #1;
        model_eval(a, rd, hit, phys, sel, pg);
        check(tag, "rdata", int'(cpu_rdata), rd);
        check(tag, "reg_hit", int'(reg_hit), hit);
        check(tag, "phys_addr", int'(phys_addr), phys);
        check(tag, "selects", int'({sram_sel, flash_sel, cart_sel, io_sel, rsvd_flag}), sel);
        check(tag, "io_page", int'(io_page), pg);
        @(posedge clk);
        if (we) model_write(a, wd);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        mode_r = 0; io_r = 0;
        for (int t = 0; t < 4; t++)
            for (int w = 0; w < 8; w++) tbl[t][w] = w;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of both bytes and identity tables, overlay on page 0 (R8)
        bus("R1", 0, 0, 0);
        bus("R1", 1, 0, 0);
        for (int w = 0; w < 8; w++) bus("R1", w * 8192 + 'h123, 0, 0);
        bus("R7", 9, 0, 0);

        // R3: unused bits read 0; edit on, edit table 1
        bus("R3", 0, 'hD4, 1);
        bus("R3", 0, 0, 0);
        bus("R3", 0, 'h90, 1);
        // R4: program low bytes of table 1; R12 readback next cycle
        bus("R4", 8, 'h45, 1);  bus("R12", 8, 0, 0);
        bus("R4", 9, 'h88, 1);  bus("R4", 10, 'hA3, 1);
        bus("R4", 11, 'h12, 1); bus("R4", 12, 'h7F, 1);
        bus("R4", 13, 'hA0, 1); bus("R4", 14, 'h3F, 1);
        bus("R4", 15, 'h40, 1);
        for (int a = 8; a < 16; a++) bus("R4", a, 0, 0);
        // R5: upper bits packing
        bus("R5", 2, 'h63, 1);
        bus("R5", 3, 'h00, 1);
        bus("R5", 2, 0, 0); bus("R5", 3, 0, 0);
        // R6: active table 0 unaffected
        for (int w = 0; w < 8; w++) bus("R6", w * 8192 + 'h1FFF, 0, 0);

        // R10: activate table 1 with extended SRAM, edit off
        bus("R12", 0, 'h09, 1);
        for (int w = 0; w < 8; w++) bus("R10", w * 8192 + 'h0AB, 0, 0);
        // R7: edit registers ignored while editing is off
        bus("R7", 9, 'hFF, 1);
        bus("R7", 2, 'hFF, 1);
        bus("R7", 9, 0, 0);
        bus("R7", 'h2000, 0, 0);
        bus("R7", 0, 'h91, 1);
        bus("R7", 9, 0, 0); bus("R7", 2, 0, 0);
        // R10: extended SRAM off makes the upper pages reserved (R11)
        bus("R10", 0, 'h01, 1);
        bus("R11", 'h0010, 0, 0);
        bus("R11", 'h6000, 0, 0);

        // R8: pages 7 (reserved), 5, 4; R9: overlay disabled
        bus("R8", 1, 'h0B, 1);  bus("R8", 'hC010, 0, 0);
        bus("R8", 1, 'h09, 1);  bus("R8", 'hDFFF, 0, 0);
        bus("R8", 1, 'h08, 1);  bus("R8", 'hC000, 0, 0);
        bus("R9", 1, 'hF4, 1);  bus("R9", 1, 0, 0);
        bus("R9", 'hC456, 0, 0);

        // R6: edit table 3 while table 0 is active
        bus("R6", 0, 'hB0, 1);
        bus("R6", 12, 'h55, 1);
        bus("R6", 'h8000, 0, 0);
        bus("R6", 0, 'h33, 1);
        bus("R6", 'h8000, 0, 0);

        // R2: pseudo-random mix of register writes and translated accesses
        seed = 32'h1234567;
        for (int i = 0; i < 400; i++) begin
            int op, a, d;
            seed = seed * 1103515245 + 12345;
            op = (seed >>> 16) & 7;
            seed = seed * 1103515245 + 12345;
            d = (seed >>> 8) & 255;
            a = (seed >>> 16) & 'hFFFF;
            if (op < 3) bus("R2", a & 15, d, 1);
            else bus("R2", a, 0, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule